// File: doc/BRIEF.md
# High-Colour Byte-Lane Splitter

This block sits on a live pixel byte stream taken from the feature-connector tap of an SVGA controller. It runs on the byte clock, and it routes each byte into one or two palette index lanes. It stores no frame. It only re-registers the incoming bytes and steers them to a lane.

A 16bpp pixel reaches the block as two consecutive bytes, with the low half first. When the divider control is high, the block pairs these bytes. The low byte of each pair goes to the secondary lane. The high byte goes to the auxiliary lane, which feeds both auxiliary palettes. One pixel strobe fires per pair, so pixels come out at half the byte rate. When the divider control is low, every byte goes straight to the secondary lane at the full byte rate, and the auxiliary lane carries index 0.

Pairing starts again after every blanking interval and after every change of the divider control, so a line always begins on a low byte. The blank and sync inputs pass through the same number of register stages as the pixel data, so they stay aligned with it.

Top module: `hc_lane_splitter`

## Requirements
- R1: While reset is asserted, both lane indexes read 0 and the pixel strobe, blank and sync outputs are low.
- R2: With the divider control low, each accepted byte (valid high, blank low) appears on the secondary index one clock later, with the pixel strobe high for that one clock.
- R3: With the divider control low, every pixel strobe presents 0 on the auxiliary index.
- R4: With the divider control high, the first accepted byte of a pair raises no strobe. One clock after the second accepted byte, the strobe is high, the secondary index equals the first byte (bits 7:0 of the pixel) and the auxiliary index equals the second byte (bits 15:8).
- R5: A byte presented with valid low is ignored. It raises no strobe and does not advance the pairing.
- R6: Bytes presented while blank is high are ignored. The first accepted byte after blank is always treated as a low byte.
- R7: A change of the divider control restarts pairing. With the divider low, a byte waiting for its partner is discarded. The first accepted byte after the divider goes high is a low byte.
- R8: The blank, horizontal-sync and vertical-sync outputs equal the matching inputs delayed by exactly one clock, which is the pixel data latency.
- R9: When the pixel strobe is low, both lane indexes keep the values they had on the previous clock.
- R10: With the divider high, a full active line of 1280 accepted bytes produces exactly 640 strobes, each carrying its own byte pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_i | input | 8 | Pixel byte from the tap |
| byte_vld_i | input | 1 | Byte qualifier |
| blank_i | input | 1 | Blanking interval active |
| hsync_i | input | 1 | Horizontal sync |
| vsync_i | input | 1 | Vertical sync |
| split_en_i | input | 1 | High-colour divider enable |
| sec_idx_o | output | 8 | Secondary lane palette index |
| aux_idx_o | output | 8 | Auxiliary lane palette index (both auxiliary palettes) |
| pix_stb_o | output | 1 | One-clock pixel strobe |
| blank_o | output | 1 | Delayed blank |
| hsync_o | output | 1 | Delayed horizontal sync |
| vsync_o | output | 1 | Delayed vertical sync |

## Verification
The assertions assume that all inputs change only away from the rising clock edge. They also assume that the divider control is steady in the clock before a strobe, because the lane checks read its past value to choose which rule applies. The bench drives every input just after a rising edge and changes the divider control only between scenarios. Data checks are taken one clock after the accepting edge, which keeps the stimulus inside these assumptions.

// File: rtl/hcs_pkg.sv
package hcs_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SYNC_W = 3;
  localparam int unsigned PIPE_LAT = 1;

  typedef logic [BYTE_W-1:0] idx_t;

  typedef struct packed {
    logic blank;
    logic hsync;
    logic vsync;
  } vid_ctl_t;
endpackage

// File: rtl/hcs_pair_fsm.sv
module hcs_pair_fsm
  import hcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  idx_t byte_i,
  input  logic byte_vld_i,
  input  logic blank_i,
  input  logic split_en_i,
  output logic emit_o,
  output idx_t emit_sec_o,
  output idx_t emit_aux_o
);
  logic take;
  logic phase_q, phase_d;
  logic low_en;
  idx_t low_q;

  assign take = byte_vld_i && !blank_i;

  always_comb begin
    phase_d = phase_q;
    if (!split_en_i || blank_i) begin
      phase_d = 1'b0;
    end else if (take) begin
      phase_d = !phase_q;
    end
  end

  assign low_en = take && split_en_i && !phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= '0;
    end else if (low_en) begin
      low_q <= byte_i;
    end
  end

  always_comb begin
    emit_o     = take && (!split_en_i || phase_q);
    emit_sec_o = split_en_i ? low_q : byte_i;
    emit_aux_o = split_en_i ? byte_i : '0;
  end
endmodule

// File: rtl/hcs_lane_reg.sv
module hcs_lane_reg
  import hcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic emit_i,
  input  idx_t sec_i,
  input  idx_t aux_i,
  output idx_t sec_o,
  output idx_t aux_o,
  output logic stb_o
);
  idx_t sec_q, aux_q;
  logic stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      aux_q <= '0;
    end else if (emit_i) begin
      sec_q <= sec_i;
      aux_q <= aux_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
    end else begin
      stb_q <= emit_i;
    end
  end

  assign sec_o = sec_q;
  assign aux_o = aux_q;
  assign stb_o = stb_q;
endmodule

// File: rtl/hcs_ctl_delay.sv
module hcs_ctl_delay #(
  parameter int unsigned W     = 3,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int unsigned STAGES = (DEPTH < 1) ? 1 : DEPTH;

  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            stage_q[g] <= '0;
          end else begin
            stage_q[g] <= d_i;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            stage_q[g] <= '0;
          end else begin
            stage_q[g] <= stage_q[g-1];
          end
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hc_lane_splitter.sv
module hc_lane_splitter
  import hcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic             byte_vld_i,
  input  logic             blank_i,
  input  logic             hsync_i,
  input  logic             vsync_i,
  input  logic             split_en_i,
  output logic [BYTE_W-1:0] sec_idx_o,
  output logic [BYTE_W-1:0] aux_idx_o,
  output logic             pix_stb_o,
  output logic             blank_o,
  output logic             hsync_o,
  output logic             vsync_o
);
  logic     emit;
  idx_t     emit_sec, emit_aux;
  vid_ctl_t ctl_in, ctl_out;

  hcs_pair_fsm u_pair (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_i     (byte_i),
    .byte_vld_i (byte_vld_i),
    .blank_i    (blank_i),
    .split_en_i (split_en_i),
    .emit_o     (emit),
    .emit_sec_o (emit_sec),
    .emit_aux_o (emit_aux)
  );

  hcs_lane_reg u_lanes (
    .clk    (clk),
    .rst_n  (rst_n),
    .emit_i (emit),
    .sec_i  (emit_sec),
    .aux_i  (emit_aux),
    .sec_o  (sec_idx_o),
    .aux_o  (aux_idx_o),
    .stb_o  (pix_stb_o)
  );

  assign ctl_in = '{blank: blank_i, hsync: hsync_i, vsync: vsync_i};

  hcs_ctl_delay #(.W(SYNC_W), .DEPTH(PIPE_LAT)) u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (ctl_in),
    .q_o   (ctl_out)
  );

  assign blank_o = ctl_out.blank;
  assign hsync_o = ctl_out.hsync;
  assign vsync_o = ctl_out.vsync;
endmodule

// File: rtl/hc_lane_splitter_chk.sv
module hc_lane_splitter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] byte_i,
  input logic       byte_vld_i,
  input logic       blank_i,
  input logic       hsync_i,
  input logic       vsync_i,
  input logic       split_en_i,
  input logic [7:0] sec_idx_o,
  input logic [7:0] aux_idx_o,
  input logic       pix_stb_o,
  input logic       blank_o,
  input logic       hsync_o,
  input logic       vsync_o
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
    end
  end

  always_comb begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!pix_stb_o && sec_idx_o == 8'h00 && aux_idx_o == 8'h00); // R1
    end
  end

  AST_STB_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && pix_stb_o |-> $past(byte_vld_i && !blank_i)); // R5

  AST_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && pix_stb_o && $past(!split_en_i) |-> sec_idx_o == $past(byte_i)); // R2

  AST_OFF_AUX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && pix_stb_o && $past(!split_en_i) |-> aux_idx_o == 8'h00); // R3

  AST_ON_HIGH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && pix_stb_o && $past(split_en_i) |-> aux_idx_o == $past(byte_i)); // R4

  AST_CTL_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> blank_o == $past(blank_i) && hsync_o == $past(hsync_i) && vsync_o == $past(vsync_i)); // R8

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !pix_stb_o |-> $stable(sec_idx_o) && $stable(aux_idx_o)); // R9

  AST_ON_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && pix_stb_o && $past(split_en_i) |=> !pix_stb_o || !$past(split_en_i)); // R10
endmodule

bind hc_lane_splitter hc_lane_splitter_chk u_chk (.*);

// File: tb/hc_lane_splitter_tb.sv
module hc_lane_splitter_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG_CYC = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] byte_i = '0;
  logic       byte_vld_i = 1'b0;
  logic       blank_i = 1'b0;
  logic       hsync_i = 1'b0;
  logic       vsync_i = 1'b0;
  logic       split_en_i = 1'b0;
  logic [7:0] sec_idx_o, aux_idx_o;
  logic       pix_stb_o, blank_o, hsync_o, vsync_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hc_lane_splitter dut_i (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] b, input logic v, input logic bl);
    byte_i = b; byte_vld_i = v; blank_i = bl;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    blank_i = 1'b1; hsync_i = 1'b1; byte_i = 8'hFF; byte_vld_i = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "stb", pix_stb_o, 0);
    chk("R1", "sec", sec_idx_o, 0);
    chk("R1", "aux", aux_idx_o, 0);
    chk("R1", "blank/hsync", {blank_o, hsync_o, vsync_o}, 0);
    byte_vld_i = 1'b0; blank_i = 1'b0; hsync_i = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic t_div_off();
    split_en_i = 1'b0;
    drive(8'h11, 1, 0);
    chk("R2", "stb", pix_stb_o, 1);
    chk("R2", "sec", sec_idx_o, 8'h11);
    chk("R3", "aux", aux_idx_o, 0);
    drive(8'h22, 1, 0);
    chk("R2", "stb 2nd", pix_stb_o, 1);
    chk("R2", "sec 2nd", sec_idx_o, 8'h22);
    drive(8'h00, 0, 0);
  endtask

  task automatic t_div_on();
    split_en_i = 1'b1;
    drive(8'h00, 0, 0);
    drive(8'h34, 1, 0);
    chk("R4", "no stb on low", pix_stb_o, 0);
    chk("R9", "sec held", sec_idx_o, 8'h22);
    drive(8'h12, 1, 0);
    chk("R4", "stb on high", pix_stb_o, 1);
    chk("R4", "sec=low", sec_idx_o, 8'h34);
    chk("R4", "aux=high", aux_idx_o, 8'h12);
    drive(8'h00, 0, 0);
    chk("R9", "aux held", aux_idx_o, 8'h12);
  endtask

  task automatic t_vld_gap();
    drive(8'h55, 1, 0);
    drive(8'hEE, 0, 0);
    chk("R5", "invalid no stb", pix_stb_o, 0);
    drive(8'h66, 1, 0);
    chk("R5", "stb after gap", pix_stb_o, 1);
    chk("R5", "sec", sec_idx_o, 8'h55);
    chk("R5", "aux", aux_idx_o, 8'h66);
    drive(8'h00, 0, 0);
  endtask

  task automatic t_blank();
    drive(8'h77, 1, 0);
    drive(8'h99, 1, 1);
    chk("R6", "blank byte no stb", pix_stb_o, 0);
    chk("R8", "blank_o", blank_o, 1);
    drive(8'h01, 1, 0);
    chk("R6", "no stb first after blank", pix_stb_o, 0);
    chk("R8", "blank_o clear", blank_o, 0);
    drive(8'h02, 1, 0);
    chk("R6", "stb", pix_stb_o, 1);
    chk("R6", "sec restarted", sec_idx_o, 8'h01);
    chk("R6", "aux", aux_idx_o, 8'h02);
    drive(8'h00, 0, 0);
  endtask

  task automatic t_sync();
    hsync_i = 1'b1;
    drive(8'h00, 0, 0);
    chk("R8", "hsync_o", hsync_o, 1);
    hsync_i = 1'b0; vsync_i = 1'b1;
    drive(8'h00, 0, 0);
    chk("R8", "hsync_o low", hsync_o, 0);
    chk("R8", "vsync_o", vsync_o, 1);
    vsync_i = 1'b0;
    drive(8'h00, 0, 0);
    chk("R8", "vsync_o low", vsync_o, 0);
  endtask

  task automatic t_switch();
    split_en_i = 1'b1;
    drive(8'hA0, 1, 0);
    split_en_i = 1'b0;
    drive(8'h00, 0, 0);
    drive(8'hB0, 1, 0);
    chk("R7", "off stb", pix_stb_o, 1);
    chk("R7", "off sec", sec_idx_o, 8'hB0);
    chk("R7", "off aux", aux_idx_o, 0);
    split_en_i = 1'b1;
    drive(8'h00, 0, 0);
    drive(8'hC0, 1, 0);
    chk("R7", "on first no stb", pix_stb_o, 0);
    drive(8'hD0, 1, 0);
    chk("R7", "on sec", sec_idx_o, 8'hC0);
    chk("R7", "on aux", aux_idx_o, 8'hD0);
    drive(8'h00, 0, 0);
  endtask

  task automatic t_line();
    int stb_cnt = 0;
    int bad = 0;
    split_en_i = 1'b1;
    drive(8'h00, 0, 1);
    for (int i = 0; i < 1280; i++) begin
      drive(8'(i * 3 + 5), 1, 0);
      if (pix_stb_o) begin
        stb_cnt++;
        if (sec_idx_o != 8'((i - 1) * 3 + 5) || aux_idx_o != 8'(i * 3 + 5)) bad++;
      end
    end
    drive(8'h00, 0, 1);
    chk("R10", "strobes per line", stb_cnt, 640);
    chk("R10", "pair mismatches", bad, 0);
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_div_off();
    t_div_on();
    t_vld_gap();
    t_blank();
    t_sync();
    t_switch();
    t_line();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule